// File: doc/BRIEF.md
# Byte-Parity Protected Synchronous FIFO

This block is a single-clock FIFO that guards every byte it stores with its own parity bit. When a word is accepted on the write side, one even-parity bit is formed for each 8-bit lane and kept in the same entry as the data. When the word at the head leaves on the read side, the parity of each lane is formed again and compared with the stored bit. Any lane that disagrees shows up on a per-lane error vector and on a combined error flag, a fixed number of cycles after the word left.

Both data sides use valid/ready handshakes. A word is written on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is simply the inverse of `full`, so a producer that holds `in_valid` high while the buffer is full is stalled and loses nothing. The read side is first-word-fall-through. `out_data` shows the oldest word whenever `out_valid` is high, and the word is removed on an edge where `out_valid` and `out_ready` are both high. `out_valid` is the inverse of `empty`. A parameter removes the protection altogether: no parity bits are stored and the error outputs stay low. A test-only input flips chosen stored parity bits at write time, so that the checking path can be exercised.

Top module: `byte_parity_fifo`

## Requirements
- R1: On a write handshake the entry stores the data word together with one parity bit per lane, where lane i is `in_data[8i+7:8i]` and its bit is the XOR of those 8 bits (even parity), XORed with `fault_flip[i]`.
- R2: Words leave in the order they were written; while `out_valid` is high, `out_data` equals the oldest stored word.
- R3: `full` is high and `in_ready` low exactly when DEPTH words are held; a write attempted while full is ignored and the stored contents are unchanged.
- R4: `empty` is high and `out_valid` low exactly when no word is held; a read attempted while empty is ignored and produces no error pulse.
- R5: For a read handshake in cycle T, a lane whose recomputed parity differs from its stored bit drives its bit of `par_err_lanes` high during cycle T+ERR_LAT only (ERR_LAT is 1 or 2); lanes that agree stay low.
- R6: `par_err` is high in exactly the cycles where any bit of `par_err_lanes` is high.
- R7: With PROTECT=0, `par_err` and `par_err_lanes` stay 0 under all traffic, including any `fault_flip` value, while data still flows as in R2.
- R8: After reset, `empty` is 1, `full` is 0, `in_ready` is 1, `out_valid` is 0 and both error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Write side: word offered |
| in_ready | output | 1 | Write side: space available |
| in_data | input | DATA_W | Write side: data word |
| fault_flip | input | DATA_W/8 | Test only: per-lane inversion of the stored parity bit |
| out_valid | output | 1 | Read side: head word present |
| out_ready | input | 1 | Read side: consumer takes the head word |
| out_data | output | DATA_W | Read side: head word |
| full | output | 1 | DEPTH words held |
| empty | output | 1 | No word held |
| par_err | output | 1 | Any lane mismatch, ERR_LAT cycles after the read |
| par_err_lanes | output | DATA_W/8 | Per-lane mismatch, ERR_LAT cycles after the read |

## Verification
On every cycle the assertions keep the occupancy within DEPTH, keep `full` and `empty` from dropping unless a read or a write happened, and tie the error outputs to the handshake mismatch exactly ERR_LAT cycles earlier. Parity itself is not modelled in any property. The bench scenarios show it instead: they inject flips on chosen lanes and see them come back on exactly those lanes, in the right cycle, for latencies 1 and 2. The scenarios also show first-in-first-out order, that writes while full and reads while empty are ignored, and that an unprotected instance stays silent under the same injected faults.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
  localparam int unsigned LANE_W = 8;

  function automatic logic lane_even_par(input logic [LANE_W-1:0] b);
    return ^b;
  endfunction
endpackage

// File: rtl/bpf_parity_gen.sv
module bpf_parity_gen #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / bpf_pkg::LANE_W
) (
  input  logic [DATA_W-1:0] word,
  output logic [LANES-1:0]  par
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign par[g] = bpf_pkg::lane_even_par(word[g*bpf_pkg::LANE_W +: bpf_pkg::LANE_W]);
  end
endmodule

// File: rtl/bpf_store.sv
module bpf_store #(
  parameter int unsigned ENTRY_W = 36,
  parameter int unsigned DEPTH   = 8,
  localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic               rd_en,
  output logic [ENTRY_W-1:0] rd_entry,
  output logic               full,
  output logic               empty
);
  localparam logic [AW:0]   CNT_MAX = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] PTR_END = AW'(DEPTH - 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wr_ptr, rd_ptr;
  logic [AW:0]        count;
  logic               do_wr, do_rd;

  assign full  = (count == CNT_MAX);
  assign empty = (count == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign rd_entry = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == PTR_END) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == PTR_END) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  occupancy_cap_chk: assert property (@(posedge clk) disable iff (rst) count <= CNT_MAX);
  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (rst) (full && !rd_en) |=> full);
  // R4
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst) (empty && !wr_en) |=> empty);
endmodule

// File: rtl/bpf_err_pipe.sv
module bpf_err_pipe #(
  parameter int unsigned LANES = 4,
  parameter int unsigned LAT   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] hit,
  output logic [LANES-1:0] hit_late
);
  logic [LANES-1:0] stage [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(LAT); i++) stage[i] <= '0;
    end else begin
      stage[0] <= hit;
      for (int i = 1; i < int'(LAT); i++) stage[i] <= stage[i-1];
    end
  end

  assign hit_late = stage[LAT-1];

  if (LAT == 1) begin : g_chk1
    // R5
    err_delay_chk: assert property (@(posedge clk) disable iff (rst) hit_late == $past(hit));
  end else begin : g_chk2
    // R5
    err_delay_chk: assert property (@(posedge clk) disable iff (rst) hit_late == $past(hit, 2));
  end
endmodule

// File: rtl/byte_parity_fifo.sv
module byte_parity_fifo #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DEPTH   = 8,
  parameter bit          PROTECT = 1'b1,
  parameter int unsigned ERR_LAT = 2,
  localparam int unsigned LANES  = DATA_W / bpf_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LANES-1:0]  fault_flip,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              full,
  output logic              empty,
  output logic              par_err,
  output logic [LANES-1:0]  par_err_lanes
);
  localparam int unsigned ENTRY_W = DATA_W + (PROTECT ? LANES : 0);

  logic [ENTRY_W-1:0] wr_entry, rd_entry;
  logic               wr_fire, rd_fire;

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign wr_fire   = in_valid && in_ready;
  assign rd_fire   = out_valid && out_ready;
  assign out_data  = rd_entry[DATA_W-1:0];

  if (PROTECT) begin : g_prot
    logic [LANES-1:0] wr_par, rd_calc, mism;

    bpf_parity_gen #(.DATA_W(DATA_W)) u_gen_wr (.word(in_data), .par(wr_par));
    bpf_parity_gen #(.DATA_W(DATA_W)) u_gen_rd (.word(rd_entry[DATA_W-1:0]), .par(rd_calc));

    assign wr_entry = {wr_par ^ fault_flip, in_data};
    assign mism     = (rd_calc ^ rd_entry[ENTRY_W-1:DATA_W]) & {LANES{rd_fire}};

    bpf_err_pipe #(.LANES(LANES), .LAT(ERR_LAT)) u_pipe (
      .clk(clk), .rst(rst), .hit(mism), .hit_late(par_err_lanes)
    );
  end else begin : g_bare
    assign wr_entry      = in_data;
    assign par_err_lanes = '0;
  end

  assign par_err = |par_err_lanes;

  bpf_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_fire), .wr_entry(wr_entry),
    .rd_en(rd_fire), .rd_entry(rd_entry),
    .full(full), .empty(empty)
  );
endmodule

// File: tb/byte_parity_fifo_bench.sv
module byte_parity_fifo_bench;
  localparam int DW = 32;
  localparam int LN = DW / 8;
  localparam int DP = 8;

  // {flip[3:0], data[31:0]}
  localparam logic [35:0] VEC [8] = '{
    {4'h0, 32'h0000_0000}, {4'h1, 32'hA5A5_0F0F}, {4'h0, 32'h1234_5678},
    {4'h4, 32'hFFFF_FFFF}, {4'h8, 32'h8000_0001}, {4'h3, 32'hDEAD_BEEF},
    {4'h0, 32'h0101_0101}, {4'hF, 32'h7E7E_81C3}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic [LN-1:0] fault_flip = '0;

  logic a_ir, a_ov, a_full, a_empty, a_err; logic [DW-1:0] a_od; logic [LN-1:0] a_el;
  logic b_ir, b_ov, b_full, b_empty, b_err; logic [DW-1:0] b_od; logic [LN-1:0] b_el;
  logic c_ir, c_ov, c_full, c_empty, c_err; logic [DW-1:0] c_od; logic [LN-1:0] c_el;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  byte_parity_fifo #(.DATA_W(DW), .DEPTH(DP), .PROTECT(1'b1), .ERR_LAT(2)) u_byte_parity_fifo (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(a_ir), .in_data(in_data),
    .fault_flip(fault_flip), .out_valid(a_ov), .out_ready(out_ready), .out_data(a_od),
    .full(a_full), .empty(a_empty), .par_err(a_err), .par_err_lanes(a_el));

  byte_parity_fifo #(.DATA_W(DW), .DEPTH(DP), .PROTECT(1'b1), .ERR_LAT(1)) u_lat1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(b_ir), .in_data(in_data),
    .fault_flip(fault_flip), .out_valid(b_ov), .out_ready(out_ready), .out_data(b_od),
    .full(b_full), .empty(b_empty), .par_err(b_err), .par_err_lanes(b_el));

  byte_parity_fifo #(.DATA_W(DW), .DEPTH(DP), .PROTECT(1'b0), .ERR_LAT(1)) u_off (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(c_ir), .in_data(in_data),
    .fault_flip(fault_flip), .out_valid(c_ov), .out_ready(out_ready), .out_data(c_od),
    .full(c_full), .empty(c_empty), .par_err(c_err), .par_err_lanes(c_el));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic off_quiet;
    chk("R7 off instance silent", {c_err, c_el}, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst = 1'b0;
    tick;
    // R8 reset state
    chk("R8 reset flags", {a_empty, a_full, a_ir, a_ov, a_err, a_el}, {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0});
    chk("R8 reset flags lat1", {b_empty, b_full, b_err}, {1'b1, 1'b0, 1'b0});

    // Table walk, write phase (R1 stores data and flipped parity)
    for (int i = 0; i < DP; i++) begin
      in_valid = 1'b1; in_data = VEC[i][31:0]; fault_flip = VEC[i][35:32];
      chk("R3 ready before full", a_ir, 1'b1);
      tick;
    end
    in_valid = 1'b0; fault_flip = '0;
    chk("R3 full after DEPTH writes", {a_full, a_ir}, {1'b1, 1'b0});
    chk("R3 full off instance", c_full, 1'b1);

    // R3 write while full is ignored
    in_valid = 1'b1; in_data = 32'hBAD0_BAD0; fault_flip = 4'hF;
    tick;
    in_valid = 1'b0; fault_flip = '0;
    chk("R3 still full", a_full, 1'b1);

    // Table walk, read phase with isolated reads
    for (int i = 0; i < DP; i++) begin
      out_ready = 1'b1;
      chk("R2 head data", {a_ov, a_od}, {1'b1, VEC[i][31:0]});
      chk("R7 data flows unprotected", c_od, VEC[i][31:0]);
      chk("R1 head data lat1", b_od, VEC[i][31:0]);
      tick;
      out_ready = 1'b0;
      chk("R5 no error one cycle after read at lat 2", a_el, 4'h0);
      chk("R5 lat1 lanes", b_el, VEC[i][35:32]);
      off_quiet();
      tick;
      chk("R5 lanes at lat 2", a_el, VEC[i][35:32]);
      chk("R6 combined flag", a_err, |VEC[i][35:32]);
      chk("R5 lat1 single pulse", b_el, 4'h0);
      off_quiet();
    end

    // R3 overflow word was dropped, R4 now empty
    chk("R4 empty after drain", {a_empty, a_ov, a_full}, {1'b1, 1'b0, 1'b0});

    // R4 read while empty ignored, no error pulse
    out_ready = 1'b1;
    tick;
    chk("R4 empty read lat1 no error", {b_err, b_el}, '0);
    tick;
    chk("R4 empty read no error", {a_err, a_el}, '0);
    chk("R4 still empty", a_empty, 1'b1);
    out_ready = 1'b0;

    // Back-to-back reads with faults, pipelined pulses (R5, R6)
    in_valid = 1'b1;
    in_data = 32'h1111_2222; fault_flip = 4'h1; tick;
    in_data = 32'h3333_4444; fault_flip = 4'h0; tick;
    in_data = 32'h5555_6666; fault_flip = 4'h8; tick;
    in_valid = 1'b0; fault_flip = '0;
    out_ready = 1'b1;
    chk("R2 burst head", a_od, 32'h1111_2222);
    tick;
    chk("R5 burst lat1 first", b_el, 4'h1);
    chk("R5 burst lat2 first not yet", a_el, 4'h0);
    chk("R2 burst second", a_od, 32'h3333_4444);
    tick;
    chk("R5 burst lat2 first", a_el, 4'h1);
    chk("R5 burst lat1 second clean", b_el, 4'h0);
    tick;
    out_ready = 1'b0;
    chk("R5 burst lat2 second clean", {a_err, a_el}, '0);
    chk("R5 burst lat1 third", b_el, 4'h8);
    off_quiet();
    tick;
    chk("R5 burst lat2 third", a_el, 4'h8);
    chk("R6 burst combined", a_err, 1'b1);
    tick;
    chk("R5 pulse lasts one cycle", {a_err, a_el}, '0);
    chk("R4 empty after burst", a_empty, 1'b1);

    // Simultaneous write and read keeps occupancy (R2)
    in_valid = 1'b1; in_data = 32'hCAFE_0001; tick;
    in_data = 32'hCAFE_0002; out_ready = 1'b1;
    chk("R2 head before swap", a_od, 32'hCAFE_0001);
    tick;
    in_valid = 1'b0; out_ready = 1'b0;
    chk("R2 head after swap", {a_ov, a_od}, {1'b1, 32'hCAFE_0002});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule